// File: doc/BRIEF.md
# Exception Vector Fetch Address Generator

This block keeps a software-writable vector-table base register. It turns an exception number into the byte address of that exception's vector entry. Entries 0 through 15 belong to the core, and entry 0 carries the initial stack pointer. External interrupt line k uses entry 16+k. Each entry is one 32-bit word.

The table size is the core entries plus the number of external lines, rounded up to a power of two with a floor of 32 words. The table must be aligned to that size. Base bits below the alignment are therefore not stored. The vector address is then built by concatenation alone: the kept base bits, the exception number field and two zero bits. No adder is needed.

A small register port reaches the base register and a read-only type register. The type register reports the external line count in groups of 32. A requester pulses a strobe with an exception number. The fetch address, or an out-of-range flag, appears one cycle later.

Top module: `vtab_vector_addr`

## Requirements
- R1: While and just after synchronous reset, the base register reads 0, and `fetch_valid` and `exc_out_of_range` are low.
- R2: The base register is at byte address 0x0. Write data bits 29 down to A are stored, where A = log2(table words) + 2. Bits 31:30 and bits A-1:0 always read zero. With 43 external lines A = 8, so writing 0x80 reads back 0. With 16 external lines A = 7, so 0x80 is kept.
- R3: The type register is at byte address 0x4. Bits 3:0 hold (L-1)/32 for L external lines, or 0 when L is 0. All other bits read zero. Writes to it change nothing.
- R4: A strobe with exception number E below the entry count (16 + L) gives `fetch_valid` high in the next cycle, with `fetch_addr` = base OR (E * 4).
- R5: A strobe with E at or above 16 + L gives `exc_out_of_range` high and `fetch_valid` low in the next cycle. `fetch_addr` keeps its previous value.
- R6: Reads at register addresses other than 0x0 and 0x4 return zero. Writes there leave both registers unchanged.
- R7: `fetch_valid` and `exc_out_of_range` are high only in the cycle after a strobe, and never both at once.
- R8: A strobe in the same cycle as a base write uses the old base. Later strobes use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 4 | Register byte address (0x0 base, 0x4 type) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| exc_req | input | 1 | Vector address request strobe |
| exc_num | input | EXC_W (9) | Exception number of the request |
| fetch_valid | output | 1 | Fetch address valid, one cycle after the strobe |
| fetch_addr | output | 32 | Registered vector byte address |
| exc_out_of_range | output | 1 | Request exceeded the implemented entry count |

## Verification
The bench builds two instances side by side from the same stimulus. One has 43 external lines, giving a 64-word table, 8 zero base bits and a type value of 1. The other has 16 lines, the 32-word minimum, with 7 zero base bits and a type value of 0. Only the two together show that bit 7 of the base is kept or dropped depending on the parameter. They also place the range limit at entry 59 in one case and entry 32 in the other, so exception numbers between those two values are legal in one instance and rejected in the other.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int CORE_ENTRIES = 16;
  localparam int MIN_TBL_LOG2 = 5;
  localparam int REG_AW       = 4;
  localparam logic [REG_AW-1:0] BASE_OFS = 4'h0;
  localparam logic [REG_AW-1:0] TYPE_OFS = 4'h4;
  localparam int BASE_TOP_BIT = 29;

  // log2 of table words: entries rounded up to a power of two, floor 32
  function automatic int tbl_log2(input int ext_lines);
    int b;
    b = $clog2(CORE_ENTRIES + ext_lines);
    if (b < MIN_TBL_LOG2) b = MIN_TBL_LOG2;
    return b;
  endfunction

  // groups-of-32 code reported in the type register
  function automatic int line_groups(input int ext_lines);
    return (ext_lines == 0) ? 0 : (ext_lines - 1) / 32;
  endfunction
endpackage

// File: rtl/vtab_base_reg.sv
module vtab_base_reg #(
  parameter int ALIGN_BITS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] base_q
);
  import vtab_pkg::*;

  logic [BASE_TOP_BIT:ALIGN_BITS] impl_q;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[31:BASE_TOP_BIT+1], wdata[ALIGN_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) impl_q <= '0;
    else if (wr_en) impl_q <= wdata[BASE_TOP_BIT:ALIGN_BITS];
  end

  // bits outside the implemented window are hardwired zero
  for (genvar b = 0; b < 32; b++) begin : g_bit
    if (b >= ALIGN_BITS && b <= BASE_TOP_BIT) begin : g_kept
      assign base_q[b] = impl_q[b];
    end else begin : g_zero
      assign base_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/vtab_reg_port.sv
module vtab_reg_port #(
  parameter int TYPE_CODE = 1
) (
  input  logic                      reg_wr,
  input  logic [vtab_pkg::REG_AW-1:0] reg_addr,
  input  logic [31:0]               base_q,
  output logic                      base_wr_en,
  output logic [31:0]               reg_rdata
);
  import vtab_pkg::*;

  localparam logic [3:0] TYPE_FIELD = 4'(TYPE_CODE);

  logic sel_base, sel_type;

  always_comb begin
    sel_base   = (reg_addr == BASE_OFS);
    sel_type   = (reg_addr == TYPE_OFS);
    base_wr_en = reg_wr && sel_base;
    if (sel_base)      reg_rdata = base_q;
    else if (sel_type) reg_rdata = {28'd0, TYPE_FIELD};
    else               reg_rdata = 32'd0;
  end
endmodule

// File: rtl/vtab_fetch_gen.sv
module vtab_fetch_gen #(
  parameter int EXC_W      = 9,
  parameter int NUM_BITS   = 6,
  parameter int ENTRIES    = 59
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [EXC_W-1:0] exc_num,
  input  logic [31:0]      base_q,
  output logic             valid_q,
  output logic             oor_q,
  output logic [31:0]      addr_q
);
  localparam int ALIGN_BITS = NUM_BITS + 2;

  logic in_range;
  logic unused_base;

  assign in_range    = (32'(exc_num) < ENTRIES);
  assign unused_base = ^base_q[ALIGN_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      oor_q   <= 1'b0;
      addr_q  <= 32'd0;
    end else begin
      valid_q <= req && in_range;
      oor_q   <= req && !in_range;
      if (req && in_range)
        addr_q <= {base_q[31:ALIGN_BITS], exc_num[NUM_BITS-1:0], 2'b00};
    end
  end
endmodule

// File: rtl/vtab_vector_addr.sv
module vtab_vector_addr #(
  parameter int NUM_EXT_IRQ = 43,
  parameter int EXC_W       = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             exc_req,
  input  logic [EXC_W-1:0] exc_num,
  output logic             fetch_valid,
  output logic [31:0]      fetch_addr,
  output logic             exc_out_of_range
);
  import vtab_pkg::*;

  localparam int NUM_BITS   = tbl_log2(NUM_EXT_IRQ);
  localparam int ALIGN_BITS = NUM_BITS + 2;
  localparam int ENTRIES    = CORE_ENTRIES + NUM_EXT_IRQ;
  localparam int TYPE_CODE  = line_groups(NUM_EXT_IRQ);

  logic [31:0] base_q;
  logic        base_wr_en;

  vtab_reg_port #(.TYPE_CODE(TYPE_CODE)) u_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .base_q(base_q),
    .base_wr_en(base_wr_en), .reg_rdata(reg_rdata)
  );

  vtab_base_reg #(.ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr_en), .wdata(reg_wdata), .base_q(base_q)
  );

  vtab_fetch_gen #(.EXC_W(EXC_W), .NUM_BITS(NUM_BITS), .ENTRIES(ENTRIES)) u_fetch (
    .clk(clk), .rst(rst), .req(exc_req), .exc_num(exc_num), .base_q(base_q),
    .valid_q(fetch_valid), .oor_q(exc_out_of_range), .addr_q(fetch_addr)
  );
endmodule

// File: rtl/vtab_vector_addr_chk.sv
module vtab_vector_addr_chk #(
  parameter int NUM_EXT_IRQ = 43,
  parameter int EXC_W       = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             exc_req,
  input logic [EXC_W-1:0] exc_num,
  input logic             fetch_valid,
  input logic [31:0]      fetch_addr,
  input logic             exc_out_of_range
);
  localparam int ENTRIES = 16 + NUM_EXT_IRQ;
  localparam int ALIGN   = vtab_pkg::tbl_log2(NUM_EXT_IRQ) + 2;

  // R4
  valid_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_req && 32'(exc_num) < ENTRIES) |=> fetch_valid);
  // R5
  oor_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_req && 32'(exc_num) >= ENTRIES) |=> (exc_out_of_range && !fetch_valid));
  // R5
  addr_hold_on_oor_chk: assert property (@(posedge clk) disable iff (rst)
    exc_out_of_range |-> $stable(fetch_addr));
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> (!fetch_valid && !exc_out_of_range));
  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_valid, exc_out_of_range}));
  // R4
  addr_word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (fetch_addr[1:0] == 2'b00));
  // R2
  base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 4'h0) |-> (reg_rdata[ALIGN-1:0] == '0 && reg_rdata[31:30] == 2'b00));
  // R3
  type_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 4'h4) |-> (reg_rdata[31:4] == 28'd0));
endmodule

bind vtab_vector_addr vtab_vector_addr_chk #(.NUM_EXT_IRQ(NUM_EXT_IRQ), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .exc_req(exc_req), .exc_num(exc_num), .fetch_valid(fetch_valid),
  .fetch_addr(fetch_addr), .exc_out_of_range(exc_out_of_range)
);

// File: tb/vtab_vector_addr_tb_top.sv
module vtab_vector_addr_tb_top;
  // expected parameters derived by hand from the requirements
  localparam logic [31:0] MASK_A = 32'h3FFF_FF00; // 43 lines: 64 words, 8 zero bits
  localparam logic [31:0] MASK_B = 32'h3FFF_FF80; // 16 lines: 32 words, 7 zero bits
  localparam int ENT_A = 59;
  localparam int ENT_B = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'd0;
  logic exc_req = 1'b0;
  logic [8:0] exc_num = 9'd0;
  logic [31:0] rd_a, rd_b, fa_a, fa_b;
  logic fv_a, fv_b, oor_a, oor_b;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] base_a = 32'd0, base_b = 32'd0;
  logic [31:0] last_a = 32'd0, last_b = 32'd0;

  always #10 clk = ~clk;

  vtab_vector_addr #(.NUM_EXT_IRQ(43)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_a), .exc_req(exc_req), .exc_num(exc_num), .fetch_valid(fv_a),
    .fetch_addr(fa_a), .exc_out_of_range(oor_a));

  vtab_vector_addr #(.NUM_EXT_IRQ(16)) dut_small_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_b), .exc_req(exc_req), .exc_num(exc_num), .fetch_valid(fv_b),
    .fetch_addr(fa_b), .exc_out_of_range(oor_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 4'h0) begin base_a = d & MASK_A; base_b = d & MASK_B; end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a,
                        input logic [31:0] ea, input logic [31:0] eb);
    reg_addr = a;
    #1;
    chk({tag, " big"}, rd_a, ea);
    chk({tag, " small"}, rd_b, eb);
  endtask

  // request one exception and check both instances the cycle after
  task automatic req_chk(input string tag, input int e);
    @(negedge clk);
    exc_req = 1'b1; exc_num = 9'(e);
    @(negedge clk);
    exc_req = 1'b0;
    if (e < ENT_A) begin
      last_a = base_a | (32'(e) << 2);
      chk({tag, " R4 valid big"}, {31'd0, fv_a}, 32'd1);
      chk({tag, " R4 addr big"}, fa_a, last_a);
    end else begin
      chk({tag, " R5 oor big"}, {30'd0, oor_a, fv_a}, 32'd2);
      chk({tag, " R5 hold big"}, fa_a, last_a);
    end
    if (e < ENT_B) begin
      last_b = base_b | (32'(e) << 2);
      chk({tag, " R4 valid small"}, {31'd0, fv_b}, 32'd1);
      chk({tag, " R4 addr small"}, fa_b, last_b);
    end else begin
      chk({tag, " R5 oor small"}, {30'd0, oor_b, fv_b}, 32'd2);
      chk({tag, " R5 hold small"}, fa_b, last_b);
    end
    @(negedge clk);
    chk({tag, " R7 pulse"}, {28'd0, fv_a, oor_a, fv_b, oor_b}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", {28'd0, fv_a, oor_a, fv_b, oor_b}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    rd_chk("R1 base after reset", 4'h0, 32'd0, 32'd0);
    chk("R1 flags after reset", {28'd0, fv_a, oor_a, fv_b, oor_b}, 32'd0);

    wr(4'h0, 32'h0000_0080);
    rd_chk("R2 bit7", 4'h0, 32'd0, 32'h80);
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R2 all ones", 4'h0, 32'h3FFF_FF00, 32'h3FFF_FF80);
    rd_chk("R3 type", 4'h4, 32'd1, 32'd0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk("R3 type after write", 4'h4, 32'd1, 32'd0);
    rd_chk("R3 base after type write", 4'h0, 32'h3FFF_FF00, 32'h3FFF_FF80);
    rd_chk("R6 unmapped read", 4'h8, 32'd0, 32'd0);
    wr(4'h8, 32'h1234_5600);
    rd_chk("R6 base after unmapped write", 4'h0, 32'h3FFF_FF00, 32'h3FFF_FF80);

    wr(4'h0, 32'h2000_1000);
    req_chk("entry0", 0);
    req_chk("last core", 15);
    req_chk("small last", 31);
    req_chk("small first oor", 32);
    req_chk("big last", 58);
    req_chk("big first oor", 59);
    req_chk("far oor", 511);

    // R8: write and request on the same edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0004_0000;
    exc_req = 1'b1; exc_num = 9'd5;
    @(negedge clk);
    reg_wr = 1'b0; exc_req = 1'b0;
    chk("R8 old base big", fa_a, base_a | 32'h14);
    chk("R8 old base small", fa_b, base_b | 32'h14);
    base_a = 32'h0004_0000; base_b = 32'h0004_0000;
    req_chk("R8 new base", 5);

    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) wr(4'h0, $urandom);
      req_chk("random", int'($urandom % 80));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule